// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Fill Flags

A nine-bit word buffer whose write side and read side each run on their own free-running clock. The two clocks may be unrelated, or one net may drive both. A port acts only when both of its two enable inputs are high. Write and read pointers are Gray-coded and one bit wider than the address. Each pointer reaches the other side through a two-stage synchronizer.

Each side keeps a small level state machine. The read side has the states `RD_EMPTY`, `RD_LOW` and `RD_AVAIL`, and the write side has `WR_ROOM`, `WR_HIGH` and `WR_FULL`. On every edge of its own clock, each machine moves to the state that the next fill count gives: its own pointer after this edge's access, against the synchronized pointer of the other side. Any state can move to any other state in one edge. `RD_EMPTY` means the count is zero. `RD_LOW` means the count is at or below the low offset. `WR_FULL` means the count equals the depth. `WR_HIGH` means the count is at or above the depth minus the high offset. The flags are decoded from these states.

Both offsets default to seven. While reset is held, a load strobe can replace them. The read bus is registered and can be floated by an output-enable input.

Top module: `afifo_top`

## Requirements
- R1: When `wr_req` and `wr_gate` are both 1 on a rising `wr_clk` edge and `full` is 0, `wr_data` is stored as the next word.
- R2: When `rd_req` and `rd_gate` are both 1 on a rising `rd_clk` edge and `empty` is 0, the oldest word appears on `rd_q` after that edge. Words leave in the order they were written.
- R3: If only one enable of a pair is 1, that port does nothing.
- R4: `full` is 1 once DEPTH words are held. A write attempted while `full` is 1 is dropped and the write pointer does not move.
- R5: A read attempted while `empty` is 1 is ignored. The read pointer and `rd_q` hold their values.
- R6: With default offsets, once the flags have settled, `almost_empty` is 1 exactly when the count is at most 7.
- R7: With default offsets, once the flags have settled, `almost_full` is 1 exactly when the count is at least DEPTH-7.
- R8: If `ofs_load` is 1 on the last `wr_clk` edge before `rst_n` rises, `ae_ofs_in` and `af_ofs_in` replace the default offsets.
- R9: When `rd_oe` is 0, `rd_q` is high-impedance. When `rd_oe` is 1, `rd_q` drives the last word read.
- R10: The flags may lag an update from the other side. `empty` never falls while no word is present, and `full` never falls while no space is free.
- R11: Operation is correct both with `rd_clk` tied to `wr_clk` and with asynchronous clocks.
- R12: While `rst_n` is 0, `empty` and `almost_empty` are 1 and `full` and `almost_full` are 0.
- R13: Each pointer changes by at most one Gray bit per edge of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Active-low reset for both sides |
| ofs_load | input | 1 | Take the offset inputs during reset |
| ae_ofs_in | input | ADDR_W | Low-water offset to load |
| af_ofs_in | input | ADDR_W | High-water offset to load |
| wr_req | input | 1 | First write enable |
| wr_gate | input | 1 | Second write enable |
| wr_data | input | DATA_W | Word to write |
| rd_req | input | 1 | First read enable |
| rd_gate | input | 1 | Second read enable |
| rd_oe | input | 1 | Drive read bus when 1 |
| rd_q | output | DATA_W | Read data, three-state |
| empty | output | 1 | No word present (read side) |
| almost_empty | output | 1 | Count at or below low offset |
| full | output | 1 | No space left (write side) |
| almost_full | output | 1 | Count at or above depth minus high offset |

## Verification
With one clock driving both sides, a write and a read can be accepted on the same edge. When that happens, each level machine must account for its own access at once and for the other side's access only through the synchronizer. The bench provokes this with a tied-clock random phase in which both enable pairs are asserted most of the time. The fill level then keeps crossing the empty and full boundaries. A queue model in the bench judges every returned word for order. At each accepted access, the model also confirms that a word really existed for a read or that space really existed for a write.

// File: rtl/afifo_pkg.sv
package afifo_pkg;
    typedef enum logic [1:0] {
        WR_ROOM = 2'd0,
        WR_HIGH = 2'd1,
        WR_FULL = 2'd2
    } wr_lvl_e;

    typedef enum logic [1:0] {
        RD_EMPTY = 2'd0,
        RD_LOW   = 2'd1,
        RD_AVAIL = 2'd2
    } rd_lvl_e;
endpackage

// File: rtl/afifo_sync.sv
module afifo_sync #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/afifo_ram.sv
module afifo_ram #(
    parameter int DATA_W = 9,
    parameter int ADDR_W = 8
) (
    input  logic              wr_clk,
    input  logic              wen,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              ren,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int WORDS = 1 << ADDR_W;

    logic [DATA_W-1:0] store [WORDS];

    always_ff @(posedge wr_clk) begin
        if (wen) begin
            store[waddr] <= wdata;
        end
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (ren) begin
            rdata <= store[raddr];
        end
    end
endmodule

// File: rtl/afifo_wr_ctl.sv
module afifo_wr_ctl
    import afifo_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              wr_clk,
    input  logic              rst_n,
    input  logic              en_a,
    input  logic              en_b,
    input  logic [ADDR_W-1:0] af_ofs,
    input  logic [ADDR_W:0]   rgray_s,
    output logic              wr_ok,
    output logic [ADDR_W-1:0] waddr,
    output logic [ADDR_W:0]   wgray,
    output logic              full,
    output logic              almost_full
);
    localparam int PW = ADDR_W + 1;
    localparam logic [PW-1:0] DEPTH_P = {1'b1, {ADDR_W{1'b0}}};

    wr_lvl_e       st, st_nx;
    logic [PW-1:0] wbin, wbin_nx, rbin_s, count_nx;

    function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    always_comb begin
        wr_ok    = en_a && en_b && (st != WR_FULL);
        wbin_nx  = wbin + {{ADDR_W{1'b0}}, wr_ok};
        rbin_s   = gray_to_bin(rgray_s);
        count_nx = wbin_nx - rbin_s;
        if (count_nx == DEPTH_P) begin
            st_nx = WR_FULL;
        end else if (count_nx >= (DEPTH_P - {1'b0, af_ofs})) begin
            st_nx = WR_HIGH;
        end else begin
            st_nx = WR_ROOM;
        end
    end

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= WR_ROOM;
        end else begin
            st <= st_nx;
        end
    end

    always_ff @(posedge wr_clk or negedge rst_n) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    always_comb begin
        waddr = wbin[ADDR_W-1:0];
        unique case (st)
            WR_ROOM: begin full = 1'b0; almost_full = 1'b0; end
            WR_HIGH: begin full = 1'b0; almost_full = 1'b1; end
            WR_FULL: begin full = 1'b1; almost_full = 1'b1; end
            default: begin full = 1'b1; almost_full = 1'b1; end
        endcase
    end
endmodule

// File: rtl/afifo_rd_ctl.sv
module afifo_rd_ctl
    import afifo_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              rd_clk,
    input  logic              rst_n,
    input  logic              en_a,
    input  logic              en_b,
    input  logic [ADDR_W-1:0] ae_ofs,
    input  logic [ADDR_W:0]   wgray_s,
    output logic              rd_ok,
    output logic [ADDR_W-1:0] raddr,
    output logic [ADDR_W:0]   rgray,
    output logic              empty,
    output logic              almost_empty
);
    localparam int PW = ADDR_W + 1;

    rd_lvl_e       st, st_nx;
    logic [PW-1:0] rbin, rbin_nx, wbin_s, count_nx;

    function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
        logic [PW-1:0] b;
        b[PW-1] = g[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

    always_comb begin
        rd_ok    = en_a && en_b && (st != RD_EMPTY);
        rbin_nx  = rbin + {{ADDR_W{1'b0}}, rd_ok};
        wbin_s   = gray_to_bin(wgray_s);
        count_nx = wbin_s - rbin_nx;
        if (count_nx == '0) begin
            st_nx = RD_EMPTY;
        end else if (count_nx <= {1'b0, ae_ofs}) begin
            st_nx = RD_LOW;
        end else begin
            st_nx = RD_AVAIL;
        end
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= RD_EMPTY;
        end else begin
            st <= st_nx;
        end
    end

    always_ff @(posedge rd_clk or negedge rst_n) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else begin
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
        end
    end

    always_comb begin
        raddr = rbin[ADDR_W-1:0];
        unique case (st)
            RD_EMPTY: begin empty = 1'b1; almost_empty = 1'b1; end
            RD_LOW:   begin empty = 1'b0; almost_empty = 1'b1; end
            RD_AVAIL: begin empty = 1'b0; almost_empty = 1'b0; end
            default:  begin empty = 1'b1; almost_empty = 1'b1; end
        endcase
    end
endmodule

// File: rtl/afifo_top.sv
module afifo_top #(
    parameter int DEPTH   = 256,
    parameter int DATA_W  = 9,
    parameter int DEF_OFS = 7
) (
    input  logic                       wr_clk,
    input  logic                       rd_clk,
    input  logic                       rst_n,
    input  logic                       ofs_load,
    input  logic [$clog2(DEPTH)-1:0]   ae_ofs_in,
    input  logic [$clog2(DEPTH)-1:0]   af_ofs_in,
    input  logic                       wr_req,
    input  logic                       wr_gate,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic                       rd_req,
    input  logic                       rd_gate,
    input  logic                       rd_oe,
    output logic [DATA_W-1:0]          rd_q,
    output logic                       empty,
    output logic                       almost_empty,
    output logic                       full,
    output logic                       almost_full
);
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int PW     = ADDR_W + 1;
    localparam logic [ADDR_W-1:0] DEF_P = ADDR_W'(DEF_OFS);

    logic [ADDR_W-1:0] ae_ofs, af_ofs, waddr, raddr;
    logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s;
    logic              wr_ok, rd_ok;
    logic [DATA_W-1:0] rdata_q;

    // Offsets are sampled on write-clock edges while reset is held and are
    // static afterwards, so the read side may use them without a synchronizer.
    always_ff @(posedge wr_clk) begin
        if (!rst_n) begin
            ae_ofs <= ofs_load ? ae_ofs_in : DEF_P;
            af_ofs <= ofs_load ? af_ofs_in : DEF_P;
        end
    end

    afifo_sync #(.W(PW)) u_sync_w2r (
        .clk (rd_clk), .rst_n (rst_n), .d (wgray), .q (wgray_s)
    );

    afifo_sync #(.W(PW)) u_sync_r2w (
        .clk (wr_clk), .rst_n (rst_n), .d (rgray), .q (rgray_s)
    );

    afifo_wr_ctl #(.ADDR_W(ADDR_W)) u_wr (
        .wr_clk      (wr_clk),
        .rst_n       (rst_n),
        .en_a        (wr_req),
        .en_b        (wr_gate),
        .af_ofs      (af_ofs),
        .rgray_s     (rgray_s),
        .wr_ok       (wr_ok),
        .waddr       (waddr),
        .wgray       (wgray),
        .full        (full),
        .almost_full (almost_full)
    );

    afifo_rd_ctl #(.ADDR_W(ADDR_W)) u_rd (
        .rd_clk       (rd_clk),
        .rst_n        (rst_n),
        .en_a         (rd_req),
        .en_b         (rd_gate),
        .ae_ofs       (ae_ofs),
        .wgray_s      (wgray_s),
        .rd_ok        (rd_ok),
        .raddr        (raddr),
        .rgray        (rgray),
        .empty        (empty),
        .almost_empty (almost_empty)
    );

    afifo_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .wr_clk (wr_clk),
        .wen    (wr_ok),
        .waddr  (waddr),
        .wdata  (wr_data),
        .rd_clk (rd_clk),
        .rst_n  (rst_n),
        .ren    (rd_ok),
        .raddr  (raddr),
        .rdata  (rdata_q)
    );

    assign rd_q = rd_oe ? rdata_q : {DATA_W{1'bz}};
endmodule

// File: rtl/afifo_checker.sv
module afifo_checker #(
    parameter int PW     = 9,
    parameter int DATA_W = 9
) (
    input logic              wr_clk,
    input logic              rd_clk,
    input logic              rst_n,
    input logic              wr_req,
    input logic              wr_gate,
    input logic              rd_req,
    input logic              rd_gate,
    input logic              full,
    input logic              empty,
    input logic [PW-1:0]     wgray,
    input logic [PW-1:0]     rgray,
    input logic [DATA_W-1:0] rdata_q
);
    p_no_overflow_r4: assert property (@(posedge wr_clk) disable iff (!rst_n)
        (full && wr_req && wr_gate) |=> $stable(wgray));

    p_no_underflow_r5: assert property (@(posedge rd_clk) disable iff (!rst_n)
        (empty && rd_req && rd_gate) |=> ($stable(rgray) && $stable(rdata_q)));

    p_wr_pair_r3: assert property (@(posedge wr_clk) disable iff (!rst_n)
        !(wr_req && wr_gate) |=> $stable(wgray));

    p_rd_pair_r3: assert property (@(posedge rd_clk) disable iff (!rst_n)
        !(rd_req && rd_gate) |=> ($stable(rgray) && $stable(rdata_q)));

    p_wgray_step_r13: assert property (@(posedge wr_clk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);

    p_rgray_step_r13: assert property (@(posedge rd_clk) disable iff (!rst_n)
        $countones(rgray ^ $past(rgray)) <= 1);
endmodule

bind afifo_top afifo_checker #(.PW(PW), .DATA_W(DATA_W)) u_chk (
    .wr_clk  (wr_clk),
    .rd_clk  (rd_clk),
    .rst_n   (rst_n),
    .wr_req  (wr_req),
    .wr_gate (wr_gate),
    .rd_req  (rd_req),
    .rd_gate (rd_gate),
    .full    (full),
    .empty   (empty),
    .wgray   (wgray),
    .rgray   (rgray),
    .rdata_q (rdata_q)
);

// File: tb/afifo_top_bench.sv
module afifo_top_bench;
    localparam int DEPTH  = 16;
    localparam int AW     = 4;
    localparam int DW     = 9;

    logic wclk = 1'b0, rclk_free = 1'b0, tie = 1'b0;
    logic rclk;
    logic rst_n = 1'b0, ofs_load = 1'b0;
    logic [AW-1:0] ae_in = '0, af_in = '0;
    logic wr_req = 0, wr_gate = 0, rd_req = 0, rd_gate = 0, rd_oe = 1;
    logic [DW-1:0] wr_data = '0;
    wire  [DW-1:0] q_bus;
    logic tb_drive = 1'b0;
    logic empty, almost_empty, full, almost_full;

    int checks = 0, errors = 0;
    logic [DW-1:0] model[$];
    logic [DW-1:0] last_word = '0;
    bit done = 0;

    always #10 wclk = ~wclk;
    always #13 rclk_free = ~rclk_free;
    assign rclk = tie ? wclk : rclk_free;
    assign q_bus = tb_drive ? {DW{1'b0}} : {DW{1'bz}};

    afifo_top #(.DEPTH(DEPTH), .DATA_W(DW)) u_afifo_top (
        .wr_clk (wclk), .rd_clk (rclk), .rst_n (rst_n),
        .ofs_load (ofs_load), .ae_ofs_in (ae_in), .af_ofs_in (af_in),
        .wr_req (wr_req), .wr_gate (wr_gate), .wr_data (wr_data),
        .rd_req (rd_req), .rd_gate (rd_gate), .rd_oe (rd_oe),
        .rd_q (q_bus), .empty (empty), .almost_empty (almost_empty),
        .full (full), .almost_full (almost_full)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] word_of(input int i);
        return DW'(i * 37 + 5);
    endfunction

    function automatic logic exp_ae(input int cnt, input int ofs);
        return cnt <= ofs;
    endfunction

    function automatic logic exp_af(input int cnt, input int ofs);
        return cnt >= DEPTH - ofs;
    endfunction

    task automatic settle();
        repeat (5) @(negedge wclk);
        repeat (5) @(negedge rclk);
    endtask

    task automatic do_reset(input logic ld, input logic [AW-1:0] ae, input logic [AW-1:0] af,
                            input logic tie_v);
        rst_n = 0; tie = tie_v; ofs_load = ld; ae_in = ae; af_in = af;
        wr_req = 0; wr_gate = 0; rd_req = 0; rd_gate = 0;
        repeat (4) @(negedge wclk);
        repeat (4) @(negedge rclk);
        @(negedge wclk);
        rst_n = 1; ofs_load = 0;
        model.delete();
    endtask

    task automatic push(input logic [DW-1:0] d);
        @(negedge wclk);
        wr_req = 1; wr_gate = 1; wr_data = d;
        if (!full) model.push_back(d);
        @(negedge wclk);
        wr_req = 0; wr_gate = 0;
    endtask

    task automatic pop_chk(input string req);
        logic [DW-1:0] e;
        bit v;
        @(negedge rclk);
        v = !empty;
        if (v) e = model.pop_front();
        rd_req = 1; rd_gate = 1;
        @(negedge rclk);
        rd_req = 0; rd_gate = 0;
        if (v) begin
            chk(req, 32'(q_bus), 32'(e));
            last_word = e;
        end
    endtask

    task automatic random_phase(input int cycles, input string tag);
        fork
            begin
                for (int n = 0; n < cycles; n++) begin
                    @(negedge wclk);
                    wr_req  = ($urandom % 100) < 70;
                    wr_gate = ($urandom % 100) < 85;
                    wr_data = DW'($urandom);
                    if (wr_req && wr_gate && !full) begin
                        chk({tag, " R10 write accepted only with space"},
                            32'(model.size() < DEPTH), 32'd1);
                        model.push_back(wr_data);
                    end
                end
                @(negedge wclk);
                wr_req = 0; wr_gate = 0;
            end
            begin
                bit pend = 0;
                logic [DW-1:0] pexp = '0;
                for (int n = 0; n < cycles; n++) begin
                    @(negedge rclk);
                    if (pend) chk({tag, " R2 random order"}, 32'(q_bus), 32'(pexp));
                    pend = 0;
                    rd_req  = ($urandom % 100) < 70;
                    rd_gate = ($urandom % 100) < 85;
                    if (rd_req && rd_gate && !empty) begin
                        chk({tag, " R10 read accepted only with data"},
                            32'(model.size() > 0), 32'd1);
                        if (model.size() > 0) begin
                            pexp = model.pop_front();
                            pend = 1;
                        end
                    end
                end
                @(negedge rclk);
                if (pend) chk({tag, " R2 random order"}, 32'(q_bus), 32'(pexp));
                rd_req = 0; rd_gate = 0;
            end
        join
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            errors++;
            $display("FAIL R11 watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        rst_n = 0;
        repeat (2) @(negedge wclk);
        chk("R12 empty in reset", 32'(empty), 1);
        chk("R12 almost_empty in reset", 32'(almost_empty), 1);
        chk("R12 full in reset", 32'(full), 0);
        chk("R12 almost_full in reset", 32'(almost_full), 0);
        do_reset(0, '0, '0, 0);

        // R3: one enable of each pair alone does nothing
        @(negedge wclk); wr_req = 1; wr_data = 9'h111;
        repeat (3) @(negedge wclk); wr_req = 0; wr_gate = 1;
        repeat (3) @(negedge wclk); wr_gate = 0;
        settle();
        chk("R3 single write enable ignored", 32'(empty), 1);

        // fill to 7, 8, 9 words
        for (int i = 0; i < 7; i++) push(word_of(i));
        settle();
        chk("R1 data present after writes", 32'(empty), 0);
        chk("R6 almost_empty at 7", 32'(almost_empty), 32'(exp_ae(7, 7)));
        push(word_of(7));
        settle();
        chk("R6 almost_empty at 8", 32'(almost_empty), 32'(exp_ae(8, 7)));
        chk("R7 almost_full at 8", 32'(almost_full), 32'(exp_af(8, 7)));
        push(word_of(8));
        settle();
        chk("R7 almost_full at 9", 32'(almost_full), 32'(exp_af(9, 7)));
        for (int i = 9; i < DEPTH; i++) push(word_of(i));
        settle();
        chk("R4 full at depth", 32'(full), 1);
        push(9'h1FF);
        settle();
        chk("R4 still full after dropped write", 32'(full), 1);
        chk("R4 model holds depth words", 32'(model.size()), 32'(DEPTH));

        // R3 on the read side
        @(negedge rclk); rd_req = 1;
        repeat (3) @(negedge rclk); rd_req = 0;
        settle();
        chk("R3 single read enable ignored", 32'(full), 1);

        for (int i = 0; i < DEPTH; i++) pop_chk("R2 directed order");
        settle();
        chk("R5 empty after draining (R4 extra word dropped)", 32'(empty), 1);
        pop_chk("R5 no data");
        settle();
        chk("R5 output held on empty read", 32'(q_bus), 32'(last_word));

        // R9 three-state
        @(negedge rclk); rd_oe = 0; tb_drive = 1;
        @(negedge rclk);
        chk("R9 bus floats when disabled", 32'(q_bus), 0);
        rd_oe = 1; tb_drive = 0;
        @(negedge rclk);
        chk("R9 bus driven when enabled", 32'(q_bus), 32'(last_word));

        // R8 programmed offsets: low 3, high 2
        do_reset(1, AW'(3), AW'(2), 0);
        for (int i = 0; i < 3; i++) push(word_of(i + 20));
        settle();
        chk("R8 almost_empty at 3 with offset 3", 32'(almost_empty), 32'(exp_ae(3, 3)));
        push(word_of(23));
        settle();
        chk("R8 almost_empty at 4 with offset 3", 32'(almost_empty), 32'(exp_ae(4, 3)));
        for (int i = 4; i < 13; i++) push(word_of(i + 20));
        settle();
        chk("R8 almost_full at 13 with offset 2", 32'(almost_full), 32'(exp_af(13, 2)));
        push(word_of(33));
        settle();
        chk("R8 almost_full at 14 with offset 2", 32'(almost_full), 32'(exp_af(14, 2)));

        // R11 random traffic, asynchronous then tied clocks
        do_reset(0, '0, '0, 0);
        random_phase(3000, "R11 async");
        do_reset(0, '0, '0, 1);
        random_phase(3000, "R11 tied");
        settle();

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule